// File: doc/BRIEF.md
# Double-Precision Compare with Condition-Field Update

This unit compares two 64-bit IEEE-754 double-precision operands and reduces the outcome to a one-hot 4-bit condition code: less-than, greater-than, equal, or unordered. On each compare strobe the code is written into one of eight 4-bit fields of a 32-bit condition register. The field is picked by a 3-bit selector. The same code is also copied into a fixed 4-bit condition-code slice of a 32-bit status word. All other condition-register fields keep their contents.

Two compare flavours are offered, selected per operation. In the quiet (unordered) flavour, only a signaling NaN raises the invalid-operation flag. In the ordered flavour, any NaN operand raises it. The condition code itself is the same in both flavours. The condition register, the status word and the invalid flag are held in registers. They change only on the clock edge that samples the compare strobe.

Bit numbering of the nibble, the register fields and the status slice is big-endian: bit 0 is the most significant bit.

Top module: `fcmp_cr_unit`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls, `cr_out`, `stat_out` and `inv_out` are all zero.
- R2: Every compare produces a code with exactly one bit set. The encodings are: less = 4'b1000 (nibble bit 0 = MSB), greater = 4'b0100, equal = 4'b0010, unordered = 4'b0001.
- R3: If either operand is a NaN, the code is unordered. A NaN has an exponent field [62:52] of all ones and a nonzero fraction [51:0].
- R4: Zeros of either sign compare equal. Infinities (exponent all ones, fraction zero) order by their sign, beyond every finite value.
- R5: Non-NaN operands with different signs order by sign. With equal signs, the magnitudes [62:0] are compared as unsigned integers, and the result is reversed when both operands are negative.
- R6: The code is written to condition-register field k (k = `fld_sel`), which occupies big-endian bits 4k..4k+3, i.e. `cr_out[31-4k -: 4]`. The other seven fields are left unchanged.
- R7: The same code appears in big-endian bits 16..19 of the status word, i.e. `stat_out[15:12]`. All other bits of `stat_out` read zero.
- R8: With `unord_mode` = 1, `inv_out` is 1 only if an operand is a signaling NaN, i.e. a NaN whose fraction bit 51 is 0.
- R9: With `unord_mode` = 0, `inv_out` is 1 if either operand is any NaN, and 0 otherwise.
- R10: In a cycle where `cmp_go` is 0, all inputs are ignored and `cr_out`, `stat_out` and `inv_out` hold their values.
- R11: The outputs reflect a compare after the rising clock edge that samples `cmp_go` = 1. Before that edge they show the previous state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_go | input | 1 | Compare strobe; state is updated on this cycle's edge |
| opnd_a | input | 64 | First double-precision operand |
| opnd_b | input | 64 | Second double-precision operand |
| fld_sel | input | 3 | Destination condition-register field |
| unord_mode | input | 1 | 1 = quiet flavour, 0 = ordered flavour |
| cr_out | output | 32 | Condition register |
| stat_out | output | 32 | Status word holding the condition-code slice |
| inv_out | output | 1 | Invalid-operation flag of the latest compare |

## Verification
The bench builds the unit with its default 64-bit format and eight fields. It sets the magnitude-compare chunk width explicitly to 16, so the 63-bit magnitude is split into four chunks that are merged by priority. Vector pairs that differ in a low chunk, or in a high chunk against an opposite difference lower down, therefore exercise that priority merge. The vectors also walk the field selector through all eight positions. This shows that each write lands in its field and leaves the neighbouring fields intact.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CC_W = 4;
  localparam logic [CC_W-1:0] CC_LT = 4'b1000;
  localparam logic [CC_W-1:0] CC_GT = 4'b0100;
  localparam logic [CC_W-1:0] CC_EQ = 4'b0010;
  localparam logic [CC_W-1:0] CC_UN = 4'b0001;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic sign;
  } opnd_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int OP_W  = 64,
  parameter int EXP_W = 11
) (
  input  logic [OP_W-1:0] opnd,
  output opnd_class_t     cls,
  output logic [OP_W-2:0] mag
);
  localparam int FRAC_W = OP_W - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              frac_nz;

  always_comb begin
    exp_f       = opnd[OP_W-2 -: EXP_W];
    frac_f      = opnd[FRAC_W-1:0];
    exp_max     = &exp_f;
    frac_nz     = |frac_f;
    mag         = opnd[OP_W-2:0];
    cls.sign    = opnd[OP_W-1];
    cls.is_nan  = exp_max && frac_nz;
    cls.is_snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
    cls.is_zero = (opnd[OP_W-2:0] == '0);
  end
endmodule

// File: rtl/fcmp_mag_order.sv
module fcmp_mag_order #(
  parameter int MAG_W   = 63,
  parameter int CHUNK_W = 16
) (
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             a_gt,
  output logic             a_lt
);
  localparam int NCH   = (MAG_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W = NCH * CHUNK_W;

  logic [PAD_W-1:0] pa;
  logic [PAD_W-1:0] pb;
  logic [NCH-1:0]   ch_gt;
  logic [NCH-1:0]   ch_lt;

  always_comb begin
    pa = '0;
    pb = '0;
    pa[MAG_W-1:0] = mag_a;
    pb[MAG_W-1:0] = mag_b;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chunk
      logic [CHUNK_W-1:0] ca;
      logic [CHUNK_W-1:0] cb;
      assign ca = pa[gi*CHUNK_W +: CHUNK_W];
      assign cb = pb[gi*CHUNK_W +: CHUNK_W];
      assign ch_gt[gi] = (ca > cb);
      assign ch_lt[gi] = (ca < cb);
    end
  endgenerate

  // Highest differing chunk decides; lower chunks are overridden.
  always_comb begin
    a_gt = 1'b0;
    a_lt = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_gt[i] || ch_lt[i]) begin
        a_gt = ch_gt[i];
        a_lt = ch_lt[i];
      end
    end
  end
endmodule

// File: rtl/fcmp_field_merge.sv
module fcmp_field_merge
  import fcmp_pkg::*;
#(
  parameter int CR_FIELDS = 8,
  parameter int SEL_W     = $clog2(CR_FIELDS)
) (
  input  logic [CR_FIELDS*CC_W-1:0] cr_cur,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          sel,
  input  logic [CC_W-1:0]           code,
  output logic [CR_FIELDS*CC_W-1:0] cr_nxt
);
  localparam int CR_W = CR_FIELDS * CC_W;

  genvar gf;
  generate
    for (gf = 0; gf < CR_FIELDS; gf++) begin : g_fld
      // field gf sits at big-endian bits 4*gf .. 4*gf+3
      localparam int HI = CR_W - 1 - gf * CC_W;
      logic hit;
      assign hit = wr_en && (sel == SEL_W'(gf));
      assign cr_nxt[HI -: CC_W] = hit ? code : cr_cur[HI -: CC_W];
    end
  endgenerate
endmodule

// File: rtl/fcmp_cr_unit.sv
module fcmp_cr_unit
  import fcmp_pkg::*;
#(
  parameter int OP_W      = 64,
  parameter int EXP_W     = 11,
  parameter int CR_FIELDS = 8,
  parameter int STAT_W    = 32,
  parameter int CC_BE_POS = 16,
  parameter int CHUNK_W   = 16,
  localparam int SEL_W    = $clog2(CR_FIELDS),
  localparam int CR_W     = CR_FIELDS * CC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_go,
  input  logic [OP_W-1:0]   opnd_a,
  input  logic [OP_W-1:0]   opnd_b,
  input  logic [SEL_W-1:0]  fld_sel,
  input  logic              unord_mode,
  output logic [CR_W-1:0]   cr_out,
  output logic [STAT_W-1:0] stat_out,
  output logic              inv_out
);
  localparam int MAG_W  = OP_W - 1;
  localparam int CC_LSB = STAT_W - CC_BE_POS - CC_W;

  opnd_class_t      cls_a;
  opnd_class_t      cls_b;
  logic [MAG_W-1:0] mag_a;
  logic [MAG_W-1:0] mag_b;
  logic             mag_gt;
  logic             mag_lt;
  logic [CC_W-1:0]  code_c;
  logic             inv_c;

  logic [CR_W-1:0]  cr_q;
  logic [CR_W-1:0]  cr_d;
  logic [CC_W-1:0]  cc_q;
  logic [CC_W-1:0]  cc_d;
  logic             inv_q;
  logic             inv_d;
  logic             upd_en;

  fcmp_classify #(.OP_W(OP_W), .EXP_W(EXP_W)) u_cls_a (
    .opnd(opnd_a), .cls(cls_a), .mag(mag_a)
  );
  fcmp_classify #(.OP_W(OP_W), .EXP_W(EXP_W)) u_cls_b (
    .opnd(opnd_b), .cls(cls_b), .mag(mag_b)
  );

  fcmp_mag_order #(.MAG_W(MAG_W), .CHUNK_W(CHUNK_W)) u_order (
    .mag_a(mag_a), .mag_b(mag_b), .a_gt(mag_gt), .a_lt(mag_lt)
  );

  // Outcome decision
  always_comb begin
    if (cls_a.is_nan || cls_b.is_nan) begin
      code_c = CC_UN;
    end else if (cls_a.is_zero && cls_b.is_zero) begin
      code_c = CC_EQ;
    end else if (cls_a.sign != cls_b.sign) begin
      code_c = cls_a.sign ? CC_LT : CC_GT;
    end else if (!mag_gt && !mag_lt) begin
      code_c = CC_EQ;
    end else begin
      code_c = (mag_gt ^ cls_a.sign) ? CC_GT : CC_LT;
    end
    if (unord_mode) inv_c = cls_a.is_snan || cls_b.is_snan;
    else            inv_c = cls_a.is_nan || cls_b.is_nan;
  end

  assign upd_en = cmp_go;

  fcmp_field_merge #(.CR_FIELDS(CR_FIELDS), .SEL_W(SEL_W)) u_merge (
    .cr_cur(cr_q), .wr_en(upd_en), .sel(fld_sel), .code(code_c), .cr_nxt(cr_d)
  );

  // Next state
  always_comb begin
    cc_d  = cc_q;
    inv_d = inv_q;
    if (upd_en) begin
      cc_d  = code_c;
      inv_d = inv_c;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q  <= '0;
      cc_q  <= '0;
      inv_q <= 1'b0;
    end else begin
      cr_q  <= cr_d;
      cc_q  <= cc_d;
      inv_q <= inv_d;
    end
  end

  always_comb begin
    stat_out = '0;
    stat_out[CC_LSB +: CC_W] = cc_q;
  end
  assign cr_out  = cr_q;
  assign inv_out = inv_q;
endmodule

// File: rtl/fcmp_cr_unit_chk.sv
module fcmp_cr_unit_chk #(
  parameter int OP_W      = 64,
  parameter int EXP_W     = 11,
  parameter int CR_FIELDS = 8,
  parameter int STAT_W    = 32,
  parameter int CC_BE_POS = 16,
  parameter int SEL_W     = 3,
  parameter int CR_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_go,
  input logic [OP_W-1:0]   opnd_a,
  input logic [OP_W-1:0]   opnd_b,
  input logic [SEL_W-1:0]  fld_sel,
  input logic              unord_mode,
  input logic [CR_W-1:0]   cr_out,
  input logic [STAT_W-1:0] stat_out,
  input logic              inv_out
);
  localparam int FRAC_W = OP_W - 1 - EXP_W;
  localparam int CC_LSB = STAT_W - CC_BE_POS - 4;

  function automatic logic [CR_W-1:0] fld_mask(input logic [SEL_W-1:0] s);
    logic [CR_W-1:0] m;
    m = '0;
    for (int f = 0; f < CR_FIELDS; f++)
      if (s == SEL_W'(f)) m[CR_W-1-4*f -: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic is_nan_f(input logic [OP_W-1:0] v);
    return (&v[OP_W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
  endfunction

  function automatic logic is_snan_f(input logic [OP_W-1:0] v);
    return is_nan_f(v) && !v[FRAC_W-1];
  endfunction

  logic any_nan;
  logic any_snan;
  logic both_zero;
  logic [3:0] cc_now;
  logic [CR_W-1:0] stat_mask;

  always_comb begin
    any_nan   = is_nan_f(opnd_a) || is_nan_f(opnd_b);
    any_snan  = is_snan_f(opnd_a) || is_snan_f(opnd_b);
    both_zero = (opnd_a[OP_W-2:0] == '0) && (opnd_b[OP_W-2:0] == '0);
    cc_now    = stat_out[CC_LSB +: 4];
    stat_mask = '0;
    stat_mask[CC_LSB +: 4] = 4'hF;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) |-> $countones(cc_now) == 1);

  a_r3_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) && $past(any_nan) |-> cc_now == 4'b0001);

  a_r4_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) && $past(both_zero) |-> cc_now == 4'b0010);

  a_r6_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) |-> ((cr_out ^ $past(cr_out)) & ~fld_mask($past(fld_sel))) == '0);

  a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) |-> (cr_out & fld_mask($past(fld_sel))) ==
                      (({{(CR_W-4){1'b0}}, cc_now} << (CR_W-4-4*$past(fld_sel))) & fld_mask($past(fld_sel))));

  a_r7_stat_rest_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_out & ~stat_mask) == '0);

  a_r8_quiet_inv: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) && $past(unord_mode) |-> inv_out == $past(any_snan));

  a_r9_ordered_inv: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go) && !$past(unord_mode) |-> inv_out == $past(any_nan));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_go) |-> $stable(cr_out) && $stable(stat_out) && $stable(inv_out));
endmodule

bind fcmp_cr_unit fcmp_cr_unit_chk #(
  .OP_W(OP_W), .EXP_W(EXP_W), .CR_FIELDS(CR_FIELDS), .STAT_W(STAT_W),
  .CC_BE_POS(CC_BE_POS), .SEL_W(SEL_W), .CR_W(CR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .fld_sel(fld_sel), .unord_mode(unord_mode), .cr_out(cr_out),
  .stat_out(stat_out), .inv_out(inv_out)
);

// File: tb/tb_fcmp_cr_unit.sv
module tb_fcmp_cr_unit;
  localparam int NV = 20;
  localparam logic [3:0] LT = 4'b1000, GT = 4'b0100, EQ = 4'b0010, UN = 4'b0001;

  localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
  localparam logic [63:0] N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000, NINF = 64'hFFF0000000000000;
  localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF, NMAX = 64'hFFEFFFFFFFFFFFFF;
  localparam logic [63:0] QN = 64'h7FF8000000000000, SN = 64'h7FF0000000000001;
  localparam logic [63:0] DN = 64'h0000000000000001;

  // {a, b, sel, unord_mode, expected code, expected invalid}
  localparam logic [136:0] VEC [NV] = '{
    {P1, P2, 3'd0, 1'b0, LT, 1'b0},
    {P2, P1, 3'd1, 1'b1, GT, 1'b0},
    {P1, P1, 3'd2, 1'b0, EQ, 1'b0},
    {PZ, NZ, 3'd3, 1'b0, EQ, 1'b0},
    {N1, N2, 3'd4, 1'b1, GT, 1'b0},
    {N2, N1, 3'd5, 1'b0, LT, 1'b0},
    {N1, P1, 3'd6, 1'b0, LT, 1'b0},
    {PINF, PMAX, 3'd7, 1'b0, GT, 1'b0},
    {NINF, NMAX, 3'd0, 1'b1, LT, 1'b0},
    {QN, P1, 3'd1, 1'b1, UN, 1'b0},
    {QN, P1, 3'd2, 1'b0, UN, 1'b1},
    {P1, SN, 3'd3, 1'b1, UN, 1'b1},
    {DN, PZ, 3'd4, 1'b0, GT, 1'b0},
    {NZ, DN, 3'd5, 1'b0, LT, 1'b0},
    {PINF, PINF, 3'd6, 1'b0, EQ, 1'b0},
    {QN, QN, 3'd7, 1'b0, UN, 1'b1},
    {64'h3FF0000000000001, 64'h3FF0000000010000, 3'd0, 1'b0, LT, 1'b0},
    {64'h3FF1000000000000, 64'h3FF0FFFFFFFFFFFF, 3'd1, 1'b0, GT, 1'b0},
    {NINF, PINF, 3'd2, 1'b1, LT, 1'b0},
    {SN, QN, 3'd3, 1'b1, UN, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_go;
  logic [63:0] opnd_a, opnd_b;
  logic [2:0]  fld_sel;
  logic        unord_mode;
  logic [31:0] cr_out, stat_out;
  logic        inv_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] shadow_cr;
  logic [3:0]  shadow_cc;
  logic        shadow_inv;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fcmp_cr_unit #(.CHUNK_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .fld_sel(fld_sel), .unord_mode(unord_mode), .cr_out(cr_out),
    .stat_out(stat_out), .inv_out(inv_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] put_fld(input logic [31:0] cr, input int s, input logic [3:0] c);
    logic [31:0] r;
    r = cr;
    r[31-4*s -: 4] = c;
    return r;
  endfunction

  task automatic check_state(input string req);
    check({req, " cr"}, cr_out, shadow_cr);
    check({req, " stat"}, stat_out, {16'h0, shadow_cc, 12'h0});
    check({req, " inv"}, {31'h0, inv_out}, {31'h0, shadow_inv});
  endtask

  initial begin
    rst_n = 1'b0; cmp_go = 1'b0; opnd_a = '0; opnd_b = '0; fld_sel = '0; unord_mode = 1'b0;
    shadow_cr = '0; shadow_cc = '0; shadow_inv = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [136:0] v;
      v = VEC[i];
      opnd_a = v[136:73]; opnd_b = v[72:9]; fld_sel = v[8:6]; unord_mode = v[5];
      cmp_go = 1'b1;
      #1 check_state("R11 before edge");
      @(negedge clk);
      cmp_go = 1'b0;
      shadow_cr  = put_fld(shadow_cr, int'(v[8:6]), v[4:1]);
      shadow_cc  = v[4:1];
      shadow_inv = v[0];
      // R2 R3 R4 R5 R6 R7 R8 R9 covered by table rows
      check($sformatf("R2/R5 code vec%0d", i), {28'h0, cr_out[31-4*int'(v[8:6]) -: 4]}, {28'h0, v[4:1]});
      check($sformatf("R6 vec%0d", i), cr_out, shadow_cr);
      check($sformatf("R7 vec%0d", i), stat_out, {16'h0, v[4:1], 12'h0});
      check($sformatf("R8/R9 vec%0d", i), {31'h0, inv_out}, {31'h0, v[0]});
    end

    // R10: inputs change with strobe low -> nothing moves
    for (int k = 0; k < 4; k++) begin
      opnd_a = QN; opnd_b = SN; fld_sel = 3'(k); unord_mode = k[0];
      @(negedge clk);
      check_state("R10 hold");
    end

    // R6: fill all eight fields with distinct codes, check whole register
    for (int f = 0; f < 8; f++) begin
      case (f % 4)
        0: begin opnd_a = P1; opnd_b = P2; shadow_cc = LT; end
        1: begin opnd_a = P2; opnd_b = P1; shadow_cc = GT; end
        2: begin opnd_a = NZ; opnd_b = PZ; shadow_cc = EQ; end
        default: begin opnd_a = P1; opnd_b = QN; shadow_cc = UN; end
      endcase
      fld_sel = 3'(f); unord_mode = 1'b1; cmp_go = 1'b1;
      @(negedge clk);
      cmp_go = 1'b0;
      shadow_cr = put_fld(shadow_cr, f, shadow_cc);
      shadow_inv = 1'b0;
      check_state("R6 field walk");
    end
    check("R6 full pattern", cr_out, 32'h84218421);

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 shadow_cr = '0; shadow_cc = '0; shadow_inv = 1'b0;
    check_state("R1 async");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule